// File: doc/BRIEF.md
# Calendar Time Register Unit

This block keeps a running time of day and calendar date in two registers on a small synchronous register bus. A once-per-second strobe advances the seconds. Carries ripple into minutes, hours, day of month, month and year. The number of days in February follows a leap flag that the host writes along with the date; the block does not work out leap years on its own.

Host writes do not reach the running registers at once. A write to the time register or the date register is held in a staging copy, and that register's busy flag is raised. The flag stays up while the write is committed over a fixed number of clock cycles, set by a parameter. Second strobes that arrive during that window advance both the staging copy and the running value. When the window ends, the staged value, with those seconds already added, replaces the running one. The running registers keep counting while the host reads them, so a read of the date followed by a read of the time can fall on either side of a rollover. Software rereads the pair until two reads agree.

A parameter picks the year field width: 6 bits, with the leap flag at bit 22, or 8 bits, with the leap flag at bit 24. The read data path is combinational from the address.

Top module: `caltime_regs`

## Requirements
- R1: After reset the status word (address 0x00) reads 0, the time word (0x08) reads 0, and the date word (0x04) holds day 1, month 1, year 0 and the leap flag clear.
- R2: The time word holds seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. The date word holds day in [4:0], month (1 to 12) in [11:8], and the year in 6 bits from bit 16 with the leap flag at bit 22. In the wide setting the year is 8 bits from bit 16 and the leap flag is at bit 24. All other bits read 0.
- R3: A write to 0x08 sets status bit 8 from the next cycle for COMMIT_CYC cycles. During that time 0x08 still shows the previous running value. After that bit 8 is 0 and the written value is visible.
- R4: A write to 0x04 behaves in the same way, using status bit 7 and the date word.
- R5: Each second strobe adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R6: A day carry wraps the day to 1 and advances the month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and after day 28 in month 2 (day 29 when the leap flag is set).
- R7: A month carry out of month 12 sets the month to 1 and adds one to the year. The year wraps to 0 after its largest value (63 narrow, 255 wide). The leap flag is left unchanged.
- R8: Second strobes that come after a write and before its commit are added to the written value. In the meantime, the previous running value keeps advancing.
- R9: Writes to 0x00, writes to any unmapped address, and writes to unused bits have no effect. Reads of unmapped addresses return 0.
- R10: Without a strobe or a commit, the time and date words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sec_tick | input | 1 | One-cycle strobe, once per second |

## Verification
The assertions assume that the host writes only legal field values: seconds and minutes up to 59, hours up to 23, month 1 to 12, and a day that exists in that month under the written leap flag. They also assume that no second strobe falls in the same cycle as a write. The bench draws every written time and date from those ranges, and it biases them toward the last second, the last day of a month and the top year so that rollovers come often. Its strobes are issued only in cycles with no bus write.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } tod_t;

  typedef struct packed {
    logic       leap;
    logic [7:0] yr;
    logic [3:0] mo;
    logic [4:0] dy;
  } date_t;

  // true on the final second of a day
  function automatic logic tod_at_end(tod_t t);
    return (t.hr >= 5'd23) && (t.mn >= 6'd59) && (t.sc >= 6'd59);
  endfunction

  function automatic tod_t tod_step(tod_t t);
    tod_t n = t;
    if (t.sc >= 6'd59) begin
      n.sc = 6'd0;
      if (t.mn >= 6'd59) begin
        n.mn = 6'd0;
        n.hr = (t.hr >= 5'd23) ? 5'd0 : t.hr + 5'd1;
      end else begin
        n.mn = t.mn + 6'd1;
      end
    end else begin
      n.sc = t.sc + 6'd1;
    end
    return n;
  endfunction

  function automatic logic [4:0] month_len(logic [3:0] mo, logic leap);
    case (mo)
      4'd2:                   return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction

  function automatic date_t date_step(date_t d, logic [7:0] ymax);
    date_t n = d;
    if (d.dy >= month_len(d.mo, d.leap)) begin
      n.dy = 5'd1;
      if (d.mo >= 4'd12) begin
        n.mo = 4'd1;
        n.yr = (d.yr >= ymax) ? 8'd0 : d.yr + 8'd1;
      end else begin
        n.mo = d.mo + 4'd1;
      end
    end else begin
      n.dy = d.dy + 5'd1;
    end
    return n;
  endfunction

endpackage

// File: rtl/caltime_commit.sv
module caltime_commit #(
  parameter int COMMIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CNT_W = (COMMIT_CYC > 1) ? $clog2(COMMIT_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(COMMIT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  // a fresh write restarts the window instead of committing
  assign fire = busy && (cnt == '0) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/caltime_tod.sv
module caltime_tod
  import caltime_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wr,
  input  tod_t wval,
  input  logic commit,
  output tod_t live,
  output logic day_carry
);
  tod_t shadow;
  tod_t src;

  assign src       = commit ? shadow : live;
  assign day_carry = tick && tod_at_end(src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
    end else begin
      live <= tick ? tod_step(src) : src;
      if (wr)
        shadow <= wval;
      else if (tick)
        shadow <= tod_step(shadow);
    end
  end
endmodule

// File: rtl/caltime_date.sv
module caltime_date
  import caltime_pkg::*;
#(
  parameter int YEAR_W = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  wr,
  input  date_t wval,
  input  logic  commit,
  output date_t live
);
  localparam logic [7:0] YMAX = 8'((1 << YEAR_W) - 1);
  localparam date_t RST_DATE = '{leap: 1'b0, yr: 8'd0, mo: 4'd1, dy: 5'd1};

  date_t shadow;
  date_t src;

  assign src = commit ? shadow : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= RST_DATE;
      shadow <= RST_DATE;
    end else begin
      live <= step ? date_step(src, YMAX) : src;
      if (wr)
        shadow <= wval;
      else if (step)
        shadow <= date_step(shadow, YMAX);
    end
  end
endmodule

// File: rtl/caltime_regs.sv
module caltime_regs
  import caltime_pkg::*;
#(
  parameter bit WIDE_YEAR  = 1'b0,
  parameter int COMMIT_CYC = 4,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              sec_tick
);
  localparam int YEAR_W   = WIDE_YEAR ? 8 : 6;
  localparam int LEAP_POS = WIDE_YEAR ? 24 : 22;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(8);
  localparam int NREG = 2;  // 0: time, 1: date

  logic [NREG-1:0] wr_hit, busy, fire;
  tod_t  tod_wval, tod_live;
  date_t date_wval, date_live;
  logic  day_carry;
  logic  time_busy, date_busy, time_fire, date_fire;

  assign wr_hit[0] = bus_we && (bus_addr == A_TIME);
  assign wr_hit[1] = bus_we && (bus_addr == A_DATE);

  for (genvar i = 0; i < NREG; i++) begin : g_commit
    caltime_commit #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_hit[i]),
      .busy  (busy[i]),
      .fire  (fire[i])
    );
  end

  assign time_busy = busy[0];
  assign date_busy = busy[1];
  assign time_fire = fire[0];
  assign date_fire = fire[1];

  always_comb begin
    tod_wval.sc = bus_wdata[5:0];
    tod_wval.mn = bus_wdata[13:8];
    tod_wval.hr = bus_wdata[20:16];
    date_wval      = '0;
    date_wval.dy   = bus_wdata[4:0];
    date_wval.mo   = bus_wdata[11:8];
    date_wval.yr[YEAR_W-1:0] = bus_wdata[16 +: YEAR_W];
    date_wval.leap = bus_wdata[LEAP_POS];
  end

  caltime_tod u_tod (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .wr        (wr_hit[0]),
    .wval      (tod_wval),
    .commit    (time_fire),
    .live      (tod_live),
    .day_carry (day_carry)
  );

  caltime_date #(.YEAR_W(YEAR_W)) u_date (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (day_carry),
    .wr     (wr_hit[1]),
    .wval   (date_wval),
    .commit (date_fire),
    .live   (date_live)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) begin
      bus_rdata[8] = time_busy;
      bus_rdata[7] = date_busy;
    end else if (bus_addr == A_TIME) begin
      bus_rdata[5:0]   = tod_live.sc;
      bus_rdata[13:8]  = tod_live.mn;
      bus_rdata[20:16] = tod_live.hr;
    end else if (bus_addr == A_DATE) begin
      bus_rdata[4:0]          = date_live.dy;
      bus_rdata[11:8]         = date_live.mo;
      bus_rdata[16 +: YEAR_W] = date_live.yr[YEAR_W-1:0];
      bus_rdata[LEAP_POS]     = date_live.leap;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, date_live.yr};
endmodule

// File: rtl/caltime_regs_chk.sv
module caltime_regs_chk
  import caltime_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              sec_tick,
  input logic              time_busy,
  input logic              date_busy,
  input logic              time_fire,
  input logic              date_fire,
  input tod_t              tod_live,
  input logic [4:0]        date_day,
  input logic [3:0]        date_mon
);
  a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8)) |=> time_busy);

  a_r4_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4)) |=> date_busy);

  a_r4_clear_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(date_busy) |-> $past(date_fire));

  a_r5_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !time_fire && tod_live.sc < 6'd59) |=>
      (tod_live.sc == $past(tod_live.sc) + 6'd1));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !time_fire) |=> $stable(tod_live));

  a_r6_day_moves_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !date_fire |=> (date_day == $past(date_day)) ||
                   (date_day == $past(date_day) + 5'd1) || (date_day == 5'd1));

  a_r7_month_moves_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !date_fire |=> (date_mon == $past(date_mon)) ||
                   (date_mon == $past(date_mon) + 4'd1) ||
                   (date_mon == 4'd1 && $past(date_mon) == 4'd12));

  a_r9_status_only_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (bus_rdata[31:9] == '0 && bus_rdata[6:0] == '0));
endmodule

bind caltime_regs caltime_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .sec_tick  (sec_tick),
  .time_busy (time_busy),
  .date_busy (date_busy),
  .time_fire (time_fire),
  .date_fire (date_fire),
  .tod_live  (tod_live),
  .date_day  (date_live.dy),
  .date_mon  (date_live.mo)
);

// File: tb/caltime_regs_bench.sv
`timescale 1ns/1ps
module caltime_regs_bench;
  localparam bit WIDE   = 1'b0;
  localparam int COMMIT = 4;
  localparam int LEAP   = WIDE ? 24 : 22;
  localparam int YMAX   = WIDE ? 255 : 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] rdata;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  caltime_regs #(.WIDE_YEAR(WIDE), .COMMIT_CYC(COMMIT), .ADDR_W(8)) u_caltime_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .sec_tick(tick)
  );

  int mh, mm, ms, md, mmo, my, ml;

  function automatic logic [31:0] pk_time(int h, int m, int s);
    return 32'((h << 16) | (m << 8) | s);
  endfunction

  function automatic logic [31:0] pk_date(int d, int mo, int y, int l);
    return 32'((l << LEAP) | (y << 16) | (mo << 8) | d);
  endfunction

  function automatic int bdim(int mo, int l);
    if (mo == 2) return 28 + l;
    if (mo inside {4, 6, 9, 11}) return 30;
    return 31;
  endfunction

  task automatic madv();
    ms = ms + 1;
    if (ms < 60) return;
    ms = 0; mm = mm + 1;
    if (mm < 60) return;
    mm = 0; mh = mh + 1;
    if (mh < 24) return;
    mh = 0; md = md + 1;
    if (md <= bdim(mmo, ml)) return;
    md = 1; mmo = mmo + 1;
    if (mmo <= 12) return;
    mmo = 1;
    my = (my == YMAX) ? 0 : my + 1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit t);
    tick = t;
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic settle();
    repeat (COMMIT) step(1'b0);
  endtask

  task automatic load(int h, int m, int s, int d, int mo, int y, int l);
    wr(8'h08, pk_time(h, m, s)); settle();
    wr(8'h04, pk_date(d, mo, y, l)); settle();
    mh = h; mm = m; ms = s; md = d; mmo = mo; my = y; ml = l;
  endtask

  task automatic cmp(string tag);
    logic [31:0] v;
    rd(8'h08, v); chk(tag, v, pk_time(mh, mm, ms));
    rd(8'h04, v); chk(tag, v, pk_date(md, mmo, my, ml));
  endtask

  task automatic corner(string tag, int h, int m, int s, int d, int mo, int y, int l,
                        int eh, int em, int es, int ed, int emo, int ey);
    logic [31:0] v;
    load(h, m, s, d, mo, y, l);
    step(1'b1);
    rd(8'h08, v); chk(tag, v, pk_time(eh, em, es));
    rd(8'h04, v); chk(tag, v, pk_date(ed, emo, ey, l));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] dmask;
    void'($urandom(32'h5eed_0c1a));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1'b0);

    // R1 reset state
    rd(8'h00, v); chk("R1 status", v, 32'h0);
    rd(8'h08, v); chk("R1 time", v, 32'h0);
    rd(8'h04, v); chk("R1 date", v, pk_date(1, 1, 0, 0));

    // R3 time write commit window
    load(1, 2, 3, 5, 6, 7, 0);
    wr(8'h08, pk_time(10, 20, 30));
    for (int i = 0; i < COMMIT; i++) begin
      rd(8'h00, v); chk("R3 busy", v, 32'h100);
      rd(8'h08, v); chk("R3 old value", v, pk_time(1, 2, 3));
      step(1'b0);
    end
    rd(8'h00, v); chk("R3 busy clear", v, 32'h0);
    rd(8'h08, v); chk("R3 new value", v, pk_time(10, 20, 30));
    mh = 10; mm = 20; ms = 30;

    // R4 date write commit window
    wr(8'h04, pk_date(9, 10, 11, 1));
    for (int i = 0; i < COMMIT; i++) begin
      rd(8'h00, v); chk("R4 busy", v, 32'h80);
      rd(8'h04, v); chk("R4 old value", v, pk_date(5, 6, 7, 0));
      step(1'b0);
    end
    rd(8'h00, v); chk("R4 busy clear", v, 32'h0);
    rd(8'h04, v); chk("R4 new value", v, pk_date(9, 10, 11, 1));
    md = 9; mmo = 10; my = 11; ml = 1;

    // R8 ticks during the window land on the written value
    wr(8'h08, pk_time(4, 5, 6));
    step(1'b1); step(1'b1);
    rd(8'h08, v); chk("R8 old keeps running", v, pk_time(10, 20, 32));
    step(1'b0); step(1'b0);
    rd(8'h08, v); chk("R8 written plus ticks", v, pk_time(4, 5, 8));
    rd(8'h00, v); chk("R8 busy clear", v, 32'h0);
    mh = 4; mm = 5; ms = 8;

    // R9 ignored writes and unmapped reads
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R9 status write ignored", v, 32'h0);
    step(1'b0);
    cmp("R9 status write leaves regs");
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, v); chk("R9 unmapped read", v, 32'h0);
    rd(8'h10, v); chk("R9 unmapped read", v, 32'h0);
    settle();
    cmp("R9 unmapped write leaves regs");
    wr(8'h08, pk_time(7, 8, 9) | ~32'h001F_3F3F); settle();
    rd(8'h08, v); chk("R9 time unused bits", v, pk_time(7, 8, 9));
    dmask = 32'h1F | 32'hF00 | 32'(YMAX << 16) | 32'(1 << LEAP);
    wr(8'h04, pk_date(3, 4, 5, 1) | ~dmask); settle();
    rd(8'h04, v); chk("R9 date unused bits", v, pk_date(3, 4, 5, 1));

    // R5/R6/R7 directed rollovers
    corner("R5 hour carry",     10, 59, 59, 12, 3, 4, 0,  11, 0, 0, 12, 3, 4);
    corner("R6 feb common",     23, 59, 59, 28, 2, 4, 0,  0, 0, 0, 1, 3, 4);
    corner("R6 feb leap 28",    23, 59, 59, 28, 2, 2, 1,  0, 0, 0, 29, 2, 2);
    corner("R6 feb leap 29",    23, 59, 59, 29, 2, 2, 1,  0, 0, 0, 1, 3, 2);
    corner("R6 thirty day",     23, 59, 59, 30, 4, 9, 0,  0, 0, 0, 1, 5, 9);
    corner("R6 thirty one day", 23, 59, 59, 31, 1, 9, 0,  0, 0, 0, 1, 2, 9);
    corner("R6 day 30 of 31",   23, 59, 59, 30, 7, 9, 0,  0, 0, 0, 31, 7, 9);
    corner("R7 year step",      23, 59, 59, 31, 12, 5, 0, 0, 0, 0, 1, 1, 6);
    corner("R7 year wrap",      23, 59, 59, 31, 12, YMAX, 1, 0, 0, 0, 1, 1, 0);

    // R2/R5/R6/R10 random, biased toward rollovers
    for (int k = 0; k < 30; k++) begin
      int h, m, s, d, mo, y, l;
      h  = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
      m  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      s  = 55 + int'($urandom % 5);
      mo = 1 + int'($urandom % 12);
      l  = int'($urandom % 2);
      d  = ($urandom % 2 == 0) ? bdim(mo, l) : 1 + int'($urandom % bdim(mo, l));
      y  = ($urandom % 4 == 0) ? YMAX : int'($urandom % (YMAX + 1));
      load(h, m, s, d, mo, y, l);
      cmp("R2 field layout");
      for (int j = 0; j < 6; j++) begin
        step(1'b1);
        madv();
        cmp("R5 R6 tick advance");
      end
      step(1'b0); step(1'b0);
      cmp("R10 hold without tick");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule